// File: doc/BRIEF.md
# Power-Aware Programmable Square-Wave Generator

The block derives a square wave from a crystal timebase. It runs a binary divider chain. A 4-bit rate code picks one of thirteen chain stages and sends that stage to a single output pin. An enable bit turns the output on and off. A fast-override bit replaces the divided tap with the undivided 32.768 kHz timebase.

Main-power validity qualifies the output. While main power is good, the enable, the override and the rate code act as described above. While main power has failed, the output stays silent unless three inputs are all set: the override, an auxiliary-backup enable and an auxiliary-supply-present flag. When all three are set, the undivided timebase keeps running.

The block runs from a clock at twice the timebase rate, 65.536 kHz. Stage 0 of the chain toggles on every edge, so stage 0 is the 32.768 kHz timebase itself. Each later stage halves the frequency of the stage before it. The output is registered, so it changes only on clock edges.

Top module: `sqwGen`

## Requirements
- R1: A synchronous reset clears the divider chain to zero. The output is 0 on the edge that follows a cycle in which reset is high.
- R2: The divider chain has 15 stages. Stage k completes a full period every 2^(k+1) clock cycles, and it goes high for the first time 2^k edges after reset is released.
- R3: With main power valid, enable 1, override 0 and rate code c in the range 3 to 15, the output follows stage c-1. Code 3 gives 8192 Hz, and each higher code halves the frequency, down to 2 Hz at code 15.
- R4: With main power valid, enable 1 and override 0, rate code 1 gives stage 7 (256 Hz) and rate code 2 gives stage 8 (128 Hz).
- R5: Rate code 0 selects no stage. With main power valid, enable 1 and override 0, the output is then held at 0.
- R6: With main power valid and enable 0, the output is 0 whatever the override and rate code are.
- R7: With main power valid, enable 1 and override 1, the output follows stage 0 (32.768 kHz) whatever the rate code is. It toggles on every edge.
- R8: With main power not valid, and override, auxiliary-backup enable and auxiliary-present all 1, the output follows stage 0 whatever the enable and rate code are.
- R9: With main power not valid and any of those three inputs at 0, the output is 0.
- R10: The output is a register. Its value after an edge depends on the inputs sampled at that edge and on the chain value after that edge. A change of rate code therefore takes effect on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the 32.768 kHz timebase rate |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 4 | Rate code selecting the divider stage |
| sqwEn | input | 1 | Square-wave enable |
| fastOvr | input | 1 | Override selecting the undivided timebase |
| pwrOk | input | 1 | Main power valid |
| auxBackupEn | input | 1 | Auxiliary backup enable |
| auxPresent | input | 1 | Auxiliary supply present |
| sqwOut | output | 1 | Registered square-wave output |

## Verification
A directed walk over all sixteen rate codes, with power good and enable set, exposes a wrong stage mapping. Code 0 separates a held-low output from a stray tap, and codes 1 and 2 separate the two low-frequency exceptions from the linear part of the table. A sweep of all eight combinations of the three auxiliary qualifiers during power fail shows that only the full combination keeps the timebase alive and that enable and rate code have no effect there. Seeded random stimulus then changes every input, reset included, on arbitrary cycles. This checks the priority between power, enable, override and rate code, and the one-edge response to a rate change, against a bench-side model of the chain.

// File: rtl/sqwGen_pkg.sv
package sqwGen_pkg;

  localparam int STAGES    = 15;
  localparam int RATE_W    = 4;
  localparam int IDX_W     = $clog2(STAGES);
  localparam int LOW_CODES = 2;   // codes 1..LOW_CODES use the low-frequency taps
  localparam int LOW_BASE  = 7;   // tap used by code 1

  typedef struct packed {
    logic             pickRaw;  // route stage 0 to the output
    logic             pickTap;  // route the selected stage to the output
    logic [IDX_W-1:0] tapIdx;   // selected stage when pickTap is set
  } sqwCtrl_t;

  // Convert a rate code into a stage index (code 0 is never looked up here)
  function automatic logic [IDX_W-1:0] tapIndex(input logic [RATE_W-1:0] code);
    logic [IDX_W-1:0] idx;
    if (int'(code) <= LOW_CODES)
      idx = IDX_W'(LOW_BASE + int'(code) - 1);
    else
      idx = IDX_W'(int'(code) - 1);
    return idx;
  endfunction

endpackage

// File: rtl/sqwControl.sv
module sqwControl
  import sqwGen_pkg::*;
(
  input  logic [RATE_W-1:0] rateSel,
  input  logic              sqwEn,
  input  logic              fastOvr,
  input  logic              pwrOk,
  input  logic              auxBackupEn,
  input  logic              auxPresent,
  output sqwCtrl_t          ctrl
);

  logic auxRawOk;

  always_comb begin
    auxRawOk = fastOvr & auxBackupEn & auxPresent;
    ctrl     = '0;
    if (!pwrOk) begin
      ctrl.pickRaw = auxRawOk;
    end else if (sqwEn) begin
      if (fastOvr) begin
        ctrl.pickRaw = 1'b1;
      end else if (rateSel != '0) begin
        ctrl.pickTap = 1'b1;
        ctrl.tapIdx  = tapIndex(rateSel);
      end
    end
  end

endmodule

// File: rtl/sqwDivider.sv
module sqwDivider
  import sqwGen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sqwCtrl_t ctrl,
  output logic     sqwOut
);

  localparam int WIDE = 2 ** IDX_W;

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chainNext;
  logic [WIDE-1:0]   chainWide;
  logic              tapBit;
  logic              sqwNext;

  always_comb begin
    chainNext = chain + 1'b1;
    chainWide = '0;
    chainWide[STAGES-1:0] = chainNext;
    tapBit  = chainWide[ctrl.tapIdx];
    sqwNext = ctrl.pickRaw ? chainNext[0] :
              ctrl.pickTap ? tapBit       : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      sqwOut <= 1'b0;
    end else begin
      chain  <= chainNext;
      sqwOut <= sqwNext;
    end
  end

endmodule

// File: rtl/sqwGen.sv
module sqwGen
  import sqwGen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              sqwEn,
  input  logic              fastOvr,
  input  logic              pwrOk,
  input  logic              auxBackupEn,
  input  logic              auxPresent,
  output logic              sqwOut
);

  sqwCtrl_t ctrl;

  sqwControl i_ctrl (
    .rateSel     (rateSel),
    .sqwEn       (sqwEn),
    .fastOvr     (fastOvr),
    .pwrOk       (pwrOk),
    .auxBackupEn (auxBackupEn),
    .auxPresent  (auxPresent),
    .ctrl        (ctrl)
  );

  sqwDivider i_div (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .sqwOut (sqwOut)
  );

endmodule

// File: rtl/sqwGen_chk.sv
module sqwGen_chk
  import sqwGen_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] rateSel,
  input logic              sqwEn,
  input logic              fastOvr,
  input logic              pwrOk,
  input logic              auxBackupEn,
  input logic              auxPresent,
  input logic              sqwOut
);

  logic auxRaw;
  logic rawMode;
  assign auxRaw  = fastOvr && auxBackupEn && auxPresent;
  assign rawMode = (pwrOk && sqwEn && fastOvr) || (!pwrOk && auxRaw);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !sqwOut);

  // R9
  fail_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwrOk && !auxRaw) |=> !sqwOut);

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrOk && !sqwEn) |=> !sqwOut);

  // R5
  code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrOk && sqwEn && !fastOvr && rateSel == '0) |=> !sqwOut);

  // R7
  raw_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrOk && sqwEn && fastOvr && $past(rawMode)) |=> (sqwOut != $past(sqwOut)));

  // R8
  aux_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwrOk && auxRaw && $past(rawMode)) |=> (sqwOut != $past(sqwOut)));

endmodule

bind sqwGen sqwGen_chk i_sqwGen_chk (
  .clk         (clk),
  .rst         (rst),
  .rateSel     (rateSel),
  .sqwEn       (sqwEn),
  .fastOvr     (fastOvr),
  .pwrOk       (pwrOk),
  .auxBackupEn (auxBackupEn),
  .auxPresent  (auxPresent),
  .sqwOut      (sqwOut)
);

// File: tb/test_sqwGen.sv
module test_sqwGen;

  localparam time CLK_PERIOD = 10ns;
  localparam int  SEED       = 20240611;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rateSel = '0;
  logic       sqwEn = 1'b0;
  logic       fastOvr = 1'b0;
  logic       pwrOk = 1'b1;
  logic       auxBackupEn = 1'b0;
  logic       auxPresent = 1'b0;
  logic       sqwOut;

  int checks = 0;
  int fails  = 0;
  logic [14:0] refChain = '0;
  logic        expOut = 1'b0;
  bit          done = 1'b0;

  sqwGen i_sqwGen (
    .clk(clk), .rst(rst), .rateSel(rateSel), .sqwEn(sqwEn), .fastOvr(fastOvr),
    .pwrOk(pwrOk), .auxBackupEn(auxBackupEn), .auxPresent(auxPresent), .sqwOut(sqwOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Stage index for a nonzero rate code, per R3 and R4
  function automatic int stageOf(input logic [3:0] code);
    if (code == 4'd1) return 7;
    if (code == 4'd2) return 8;
    return int'(code) - 1;
  endfunction

  function automatic logic model(input logic [14:0] ch);
    if (!pwrOk) return (fastOvr && auxBackupEn && auxPresent) ? ch[0] : 1'b0;
    if (!sqwEn) return 1'b0;
    if (fastOvr) return ch[0];
    if (rateSel == 4'd0) return 1'b0;
    return ch[stageOf(rateSel)];
  endfunction

  function automatic string reqOf();
    if (rst) return "R1";
    if (!pwrOk) return (fastOvr && auxBackupEn && auxPresent) ? "R8" : "R9";
    if (!sqwEn) return "R6";
    if (fastOvr) return "R7";
    if (rateSel == 4'd0) return "R5";
    if (rateSel <= 4'd2) return "R4";
    return "R3";
  endfunction

  // One clock: inputs are already driven, model the edge, compare away from it
  task automatic step(input string tag);
    string r;
    r = (tag == "") ? reqOf() : tag;
    @(posedge clk);
    if (rst) begin
      refChain = '0;
      expOut   = 1'b0;
    end else begin
      refChain = refChain + 1'b1;
      expOut   = model(refChain);
    end
    @(negedge clk);
    checks++;
    if (sqwOut !== expOut) begin
      fails++;
      $display("FAIL %s: sqwOut=%0b expected %0b (rate=%0d en=%0b ovr=%0b pwr=%0b aux=%0b%0b)",
               r, sqwOut, expOut, rateSel, sqwEn, fastOvr, pwrOk, auxBackupEn, auxPresent);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, cycles=%0d expected fewer", checks);
    finish();
  end

  initial begin
    void'($urandom(SEED));
    @(negedge clk);
    // R1: reset state
    step("R1");
    step("R1");
    rst = 1'b0;

    // R2: stage 14 rises for the first time 2^14 edges after release
    sqwEn = 1'b1; rateSel = 4'd15;
    for (int i = 0; i < 16384; i++) step("R2");

    // R3 R4 R5: walk every rate code from a fresh reset
    for (int c = 0; c < 16; c++) begin
      rst = 1'b1; step("R1"); rst = 1'b0;
      rateSel = 4'(c);
      for (int i = 0; i < 600; i++) step("");
    end

    // R10: rate code changes on consecutive edges
    for (int i = 0; i < 64; i++) begin
      rateSel = 4'(i % 16);
      step("R10");
    end

    // R6: enable off, all other settings tried
    sqwEn = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rateSel = 4'(i); fastOvr = i[4];
      step("R6");
    end

    // R7: override wins over any rate code
    sqwEn = 1'b1; fastOvr = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rateSel = 4'(i);
      step("R7");
    end

    // R8 R9: every qualifier combination during power fail
    pwrOk = 1'b0;
    for (int q = 0; q < 8; q++) begin
      fastOvr = q[0]; auxBackupEn = q[1]; auxPresent = q[2];
      for (int i = 0; i < 16; i++) begin
        sqwEn = i[0]; rateSel = 4'(i * 3);
        step((q == 7) ? "R8" : "R9");
      end
    end

    // Random mix of everything
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) rst = 1'b1; else rst = 1'b0;
      if ($urandom_range(0, 3) == 0) rateSel = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) sqwEn = ~sqwEn;
      if ($urandom_range(0, 15) == 0) fastOvr = ~fastOvr;
      if ($urandom_range(0, 31) == 0) pwrOk = ~pwrOk;
      if ($urandom_range(0, 7) == 0) auxBackupEn = ~auxBackupEn;
      if ($urandom_range(0, 7) == 0) auxPresent = ~auxPresent;
      step("");
    end

    finish();
  end

endmodule